// File: doc/BRIEF.md
# Write-Guarded Program Memory Port with Block Copy

This block sits between a sub-processor's write bus and its program memory. It turns processor byte and word stores into memory write-port cycles with per-byte lane enables. It also runs a block-copy engine that moves 16-bit words from a 16 KB staging buffer into the memory. Both the buffer and the memory sit outside the block. The block drives a word address into the buffer, takes the read data back in the same cycle, and drives the memory through a single write port.

An 8-bit guard register sets a floor in 512-byte steps. Any processor store below the floor is dropped. A copy is checked only at its first destination address. If that address is below the floor, the whole copy is dropped. In every case where a start is accepted, the destination and source registers move forward as if the copy had run, so the next copy continues from the right place. The destination register counts in 8-byte units and the source register in bytes.

Top module: `prgram_ctrl`

## Requirements
- R1: After reset the guard, destination and source registers read 0, `dma_busy` is 0 and `ram_we` is 0.
- R2: A processor store targets byte address `cpu_addr[18:0]`, with bit 0 forced to 0 for a word store. `ram_addr` is that byte address shifted right by one.
- R3: A word store enables both lanes (`ram_be`=11) and passes `cpu_wdata` through. A byte store replicates `cpu_wdata[7:0]` onto both halves and enables one lane: bit 1 (the upper half) when the byte address is even, bit 0 when it is odd.
- R4: A processor store is performed only when its byte address is at or above `prot_q`×512. Otherwise `ram_we` stays 0 in that cycle.
- R5: A copy's first destination byte address is (`dst_q`<<3) masked to 19 bits with bit 0 cleared. Its first source byte address is `src_q` masked to 14 bits with bit 0 cleared. `buf_addr` and `ram_addr` are these byte addresses shifted right by one.
- R6: An accepted start with N words adds floor(N/4) to `dst_q` and 2N to `src_q`, both modulo 2^16, on the accepting edge. This happens whether or not any word is written.
- R7: If the first destination byte address is below the guard floor, no word of that copy is written and `dma_busy` stays 0.
- R8: A copy of N words writes one word per free cycle, with `dma_busy` high until the last word. Destination and source each advance by 2 bytes per word, wrapping at 19 and 14 bits respectively.
- R9: A start presented while `dma_busy` is 1 is ignored and does not move the registers.
- R10: A processor store request takes the write port in its cycle. The pending copy word is held for one cycle, and a request that is itself guarded writes nothing.
- R11: A start with N=0 writes nothing, leaves `dma_busy` at 0 and leaves both registers unchanged.
- R12: Each copied word is written with `ram_be`=11 and carries `buf_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor store request |
| cpu_word | input | 1 | 1 = word store, 0 = byte store |
| cpu_addr | input | 24 | Processor byte address |
| cpu_wdata | input | 16 | Store data (byte in bits 7:0) |
| prot_wr | input | 1 | Load guard register |
| prot_wdata | input | 8 | New guard value (512-byte units) |
| dst_wr | input | 1 | Load destination register |
| dst_wdata | input | 16 | New destination value (8-byte units) |
| src_wr | input | 1 | Load source register |
| src_wdata | input | 16 | New source value (bytes) |
| dma_start | input | 1 | Copy start command |
| dma_words | input | 16 | Copy length in words |
| buf_addr | output | 13 | Staging buffer word address |
| buf_rdata | input | 16 | Staging buffer read data |
| ram_we | output | 1 | Memory write strobe |
| ram_addr | output | 18 | Memory word address |
| ram_be | output | 2 | Lane enables (bit 1 = upper byte) |
| ram_wdata | output | 16 | Memory write data |
| dma_busy | output | 1 | Copy in progress |
| prot_q | output | 8 | Guard register |
| dst_q | output | 16 | Destination register |
| src_q | output | 16 | Source register |

## Verification
Processor stores are tried with even and odd byte addresses, word stores at odd addresses and addresses with high bits set. These separate lane selection from address masking. Guard tests put stores one byte below, and exactly at, the floor. A copy is also started at exactly the floor and one destination unit below it, which separates the allowed case from the dropped case and shows that the registers still advance. Further copies are run across the 19-bit and 14-bit wrap points, restarted while busy, interrupted by a processor store, and given a zero length. Each of these separates ordering, stall and length handling from plain sequential copying.

// File: rtl/prgram_pkg.sv
package prgram_pkg;

  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_CPU  = 2'd1,
    PORT_DMA  = 2'd2
  } port_owner_e;

  function automatic logic [31:0] low_mask(input int unsigned bits);
    return (32'd1 << bits) - 32'd1;
  endfunction

  // byte address a processor store lands on
  function automatic logic [31:0] cpu_target(input logic [31:0] addr,
                                             input logic is_word,
                                             input int unsigned aw);
    logic [31:0] a;
    a = addr & low_mask(aw);
    if (is_word) a[0] = 1'b0;
    return a;
  endfunction

  // lowest writable byte address
  function automatic logic [31:0] guard_floor(input logic [31:0] prot,
                                              input int unsigned shift);
    return prot << shift;
  endfunction

  function automatic logic [31:0] dma_dst_origin(input logic [31:0] reg_v,
                                                 input int unsigned shift,
                                                 input int unsigned aw);
    return (reg_v << shift) & low_mask(aw) & ~32'd1;
  endfunction

  function automatic logic [31:0] dma_src_origin(input logic [31:0] reg_v,
                                                 input int unsigned aw);
    return reg_v & low_mask(aw) & ~32'd1;
  endfunction

  function automatic logic [31:0] dst_advance(input logic [31:0] words);
    return words >> 2;
  endfunction

  function automatic logic [31:0] src_advance(input logic [31:0] words);
    return words << 1;
  endfunction

endpackage

// File: rtl/prgram_regs.sv
module prgram_regs #(
  parameter int BOUND_W = 8,
  parameter int REG_W   = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prot_wr,
  input  logic [BOUND_W-1:0] prot_wdata,
  input  logic               dst_wr,
  input  logic [REG_W-1:0]   dst_wdata,
  input  logic               src_wr,
  input  logic [REG_W-1:0]   src_wdata,
  input  logic               advance,
  input  logic [CNT_W-1:0]   adv_words,
  output logic [BOUND_W-1:0] prot_q,
  output logic [REG_W-1:0]   dst_q,
  output logic [REG_W-1:0]   src_q
);

  logic [REG_W-1:0] dst_inc;
  logic [REG_W-1:0] src_inc;

  assign dst_inc = REG_W'(prgram_pkg::dst_advance(32'(adv_words)));
  assign src_inc = REG_W'(prgram_pkg::src_advance(32'(adv_words)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
      dst_q  <= '0;
      src_q  <= '0;
    end else begin
      if (prot_wr) prot_q <= prot_wdata;
      // an accepted start moves both pointers; it outranks a load
      if (advance) begin
        dst_q <= dst_q + dst_inc;
        src_q <= src_q + src_inc;
      end else begin
        if (dst_wr) dst_q <= dst_wdata;
        if (src_wr) src_q <= src_wdata;
      end
    end
  end

endmodule

// File: rtl/prgram_dma_engine.sv
module prgram_dma_engine #(
  parameter int REG_W       = 16,
  parameter int BOUND_W     = 8,
  parameter int CNT_W       = 16,
  parameter int RAM_AW      = 19,
  parameter int SRC_AW      = 14,
  parameter int BOUND_SHIFT = 9,
  parameter int DST_SHIFT   = 3,
  parameter int LANE_BITS   = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CNT_W-1:0]            words,
  input  logic [REG_W-1:0]            dst_q,
  input  logic [REG_W-1:0]            src_q,
  input  logic [BOUND_W-1:0]          prot_q,
  input  logic                        hold,
  output logic                        busy,
  output logic                        taken,
  output logic                        blocked,
  output logic                        launch,
  output logic                        step,
  output logic [RAM_AW-LANE_BITS-1:0] dst_word,
  output logic [SRC_AW-LANE_BITS-1:0] src_word
);

  localparam int WORD_AW = RAM_AW - LANE_BITS;
  localparam int SRC_WAW = SRC_AW - LANE_BITS;

  logic [CNT_W-1:0] remaining;
  logic             below;

  assign below = prgram_pkg::dma_dst_origin(32'(dst_q), DST_SHIFT, RAM_AW)
               < prgram_pkg::guard_floor(32'(prot_q), BOUND_SHIFT);

  assign taken   = start && !busy;
  assign blocked = taken && below;
  assign launch  = taken && !below && (words != '0);
  assign step    = busy && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remaining <= '0;
      dst_word  <= '0;
      src_word  <= '0;
    end else if (launch) begin
      busy      <= 1'b1;
      remaining <= words;
      dst_word  <= WORD_AW'(prgram_pkg::dma_dst_origin(32'(dst_q), DST_SHIFT, RAM_AW) >> LANE_BITS);
      src_word  <= SRC_WAW'(prgram_pkg::dma_src_origin(32'(src_q), SRC_AW) >> LANE_BITS);
    end else if (step) begin
      remaining <= remaining - CNT_W'(1);
      dst_word  <= dst_word + WORD_AW'(1);
      src_word  <= src_word + SRC_WAW'(1);
      if (remaining == CNT_W'(1)) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/prgram_port_mux.sv
module prgram_port_mux #(
  parameter int CPU_AW      = 24,
  parameter int RAM_AW      = 19,
  parameter int BOUND_W     = 8,
  parameter int BOUND_SHIFT = 9,
  parameter int LANES       = 2
) (
  input  logic                                 cpu_wr,
  input  logic                                 cpu_word,
  input  logic [CPU_AW-1:0]                    cpu_addr,
  input  logic [8*LANES-1:0]                   cpu_wdata,
  input  logic [BOUND_W-1:0]                   prot_q,
  input  logic                                 dma_step,
  input  logic [RAM_AW-$clog2(LANES)-1:0]      dma_dst_word,
  input  logic [8*LANES-1:0]                   buf_rdata,
  output logic                                 ram_we,
  output logic [RAM_AW-$clog2(LANES)-1:0]      ram_addr,
  output logic [LANES-1:0]                     ram_be,
  output logic [8*LANES-1:0]                   ram_wdata,
  output logic                                 cpu_granted
);

  localparam int DATA_W    = 8 * LANES;
  localparam int LANE_BITS = $clog2(LANES);

  prgram_pkg::port_owner_e owner;

  logic [RAM_AW-1:0]    cpu_byte;
  logic                 cpu_ok;
  logic [LANE_BITS-1:0] cpu_lane;
  logic [LANES-1:0]     cpu_be;
  logic [DATA_W-1:0]    cpu_data;

  assign cpu_byte = RAM_AW'(prgram_pkg::cpu_target(32'(cpu_addr), cpu_word, RAM_AW));
  assign cpu_ok   = 32'(cpu_byte) >= prgram_pkg::guard_floor(32'(prot_q), BOUND_SHIFT);
  // lowest byte address maps to the most significant lane
  assign cpu_lane = LANE_BITS'(LANES - 1) - cpu_byte[LANE_BITS-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cpu_be[g]         = cpu_word | (cpu_lane == LANE_BITS'(g));
    assign cpu_data[g*8 +: 8] = cpu_word ? cpu_wdata[g*8 +: 8] : cpu_wdata[7:0];
  end

  always_comb begin
    owner = prgram_pkg::PORT_IDLE;
    if (cpu_wr && cpu_ok)  owner = prgram_pkg::PORT_CPU;
    else if (dma_step)     owner = prgram_pkg::PORT_DMA;
  end

  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_be    = '0;
    ram_wdata = '0;
    case (owner)
      prgram_pkg::PORT_CPU: begin
        ram_we    = 1'b1;
        ram_addr  = cpu_byte[RAM_AW-1:LANE_BITS];
        ram_be    = cpu_be;
        ram_wdata = cpu_data;
      end
      prgram_pkg::PORT_DMA: begin
        ram_we    = 1'b1;
        ram_addr  = dma_dst_word;
        ram_be    = '1;
        ram_wdata = buf_rdata;
      end
      default: ;
    endcase
  end

  assign cpu_granted = (owner == prgram_pkg::PORT_CPU);

endmodule

// File: rtl/prgram_ctrl.sv
module prgram_ctrl #(
  parameter int CPU_AW      = 24,
  parameter int RAM_AW      = 19,
  parameter int SRC_AW      = 14,
  parameter int REG_W       = 16,
  parameter int BOUND_W     = 8,
  parameter int BOUND_SHIFT = 9,
  parameter int DST_SHIFT   = 3,
  parameter int CNT_W       = 16,
  parameter int LANES       = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cpu_wr,
  input  logic                                 cpu_word,
  input  logic [CPU_AW-1:0]                    cpu_addr,
  input  logic [8*LANES-1:0]                   cpu_wdata,
  input  logic                                 prot_wr,
  input  logic [BOUND_W-1:0]                   prot_wdata,
  input  logic                                 dst_wr,
  input  logic [REG_W-1:0]                     dst_wdata,
  input  logic                                 src_wr,
  input  logic [REG_W-1:0]                     src_wdata,
  input  logic                                 dma_start,
  input  logic [CNT_W-1:0]                     dma_words,
  output logic [SRC_AW-$clog2(LANES)-1:0]      buf_addr,
  input  logic [8*LANES-1:0]                   buf_rdata,
  output logic                                 ram_we,
  output logic [RAM_AW-$clog2(LANES)-1:0]      ram_addr,
  output logic [LANES-1:0]                     ram_be,
  output logic [8*LANES-1:0]                   ram_wdata,
  output logic                                 dma_busy,
  output logic [BOUND_W-1:0]                   prot_q,
  output logic [REG_W-1:0]                     dst_q,
  output logic [REG_W-1:0]                     src_q
);

  localparam int LANE_BITS = $clog2(LANES);
  localparam int WORD_AW   = RAM_AW - LANE_BITS;
  localparam int SRC_WAW   = SRC_AW - LANE_BITS;

  // named internal events, observed by the bound checker
  logic               dma_taken;
  logic               dma_blocked;
  logic               dma_launch;
  logic               dma_step;
  logic               cpu_hold;
  logic               cpu_granted;
  logic [WORD_AW-1:0] dma_dst_word;
  logic [SRC_WAW-1:0] dma_src_word;

  assign cpu_hold = cpu_wr;
  assign buf_addr = dma_src_word;

  prgram_regs #(
    .BOUND_W (BOUND_W),
    .REG_W   (REG_W),
    .CNT_W   (CNT_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .prot_wr    (prot_wr),
    .prot_wdata (prot_wdata),
    .dst_wr     (dst_wr),
    .dst_wdata  (dst_wdata),
    .src_wr     (src_wr),
    .src_wdata  (src_wdata),
    .advance    (dma_taken),
    .adv_words  (dma_words),
    .prot_q     (prot_q),
    .dst_q      (dst_q),
    .src_q      (src_q)
  );

  prgram_dma_engine #(
    .REG_W       (REG_W),
    .BOUND_W     (BOUND_W),
    .CNT_W       (CNT_W),
    .RAM_AW      (RAM_AW),
    .SRC_AW      (SRC_AW),
    .BOUND_SHIFT (BOUND_SHIFT),
    .DST_SHIFT   (DST_SHIFT),
    .LANE_BITS   (LANE_BITS)
  ) u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dma_start),
    .words    (dma_words),
    .dst_q    (dst_q),
    .src_q    (src_q),
    .prot_q   (prot_q),
    .hold     (cpu_hold),
    .busy     (dma_busy),
    .taken    (dma_taken),
    .blocked  (dma_blocked),
    .launch   (dma_launch),
    .step     (dma_step),
    .dst_word (dma_dst_word),
    .src_word (dma_src_word)
  );

  prgram_port_mux #(
    .CPU_AW      (CPU_AW),
    .RAM_AW      (RAM_AW),
    .BOUND_W     (BOUND_W),
    .BOUND_SHIFT (BOUND_SHIFT),
    .LANES       (LANES)
  ) u_mux (
    .cpu_wr       (cpu_wr),
    .cpu_word     (cpu_word),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .prot_q       (prot_q),
    .dma_step     (dma_step),
    .dma_dst_word (dma_dst_word),
    .buf_rdata    (buf_rdata),
    .ram_we       (ram_we),
    .ram_addr     (ram_addr),
    .ram_be       (ram_be),
    .ram_wdata    (ram_wdata),
    .cpu_granted  (cpu_granted)
  );

endmodule

// File: rtl/prgram_ctrl_chk.sv
module prgram_ctrl_chk #(
  parameter int REG_W       = 16,
  parameter int BOUND_W     = 8,
  parameter int CNT_W       = 16,
  parameter int WORD_AW     = 18,
  parameter int LANES       = 2,
  parameter int LANE_BITS   = 1,
  parameter int BOUND_SHIFT = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr,
  input logic               cpu_word,
  input logic               dst_wr,
  input logic               src_wr,
  input logic               dma_start,
  input logic [CNT_W-1:0]   dma_words,
  input logic               ram_we,
  input logic [WORD_AW-1:0] ram_addr,
  input logic [LANES-1:0]   ram_be,
  input logic               dma_busy,
  input logic [BOUND_W-1:0] prot_q,
  input logic [REG_W-1:0]   dst_q,
  input logic [REG_W-1:0]   src_q,
  input logic               dma_step,
  input logic               dma_blocked,
  input logic               dma_taken,
  input logic [WORD_AW-1:0] dma_dst_word,
  input logic               cpu_granted
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!dma_busy && prot_q == '0 && dst_q == '0 && src_q == '0));

  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_granted && !cpu_word |-> $countones(ram_be) == 1);

  assert_word_all_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_granted && cpu_word |-> &ram_be);

  assert_cpu_above_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && !dma_busy |->
      (32'(ram_addr) << LANE_BITS) >= (32'(prot_q) << BOUND_SHIFT));

  assert_dst_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_taken |=> dst_q == $past(dst_q) + REG_W'($past(dma_words) >> 2));

  assert_blocked_stays_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_blocked |=> !dma_busy);

  assert_sequential_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_step |=> !dma_busy || dma_dst_word == $past(dma_dst_word) + WORD_AW'(1));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy && dma_start && !dst_wr && !src_wr |=> $stable(dst_q) && $stable(src_q));

  assert_copy_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy && cpu_wr |=> $stable(dma_dst_word));

  assert_guarded_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !cpu_granted |-> !ram_we);

endmodule

bind prgram_ctrl prgram_ctrl_chk #(
  .REG_W       (REG_W),
  .BOUND_W     (BOUND_W),
  .CNT_W       (CNT_W),
  .WORD_AW     (WORD_AW),
  .LANES       (LANES),
  .LANE_BITS   (LANE_BITS),
  .BOUND_SHIFT (BOUND_SHIFT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_wr       (cpu_wr),
  .cpu_word     (cpu_word),
  .dst_wr       (dst_wr),
  .src_wr       (src_wr),
  .dma_start    (dma_start),
  .dma_words    (dma_words),
  .ram_we       (ram_we),
  .ram_addr     (ram_addr),
  .ram_be       (ram_be),
  .dma_busy     (dma_busy),
  .prot_q       (prot_q),
  .dst_q        (dst_q),
  .src_q        (src_q),
  .dma_step     (dma_step),
  .dma_blocked  (dma_blocked),
  .dma_taken    (dma_taken),
  .dma_dst_word (dma_dst_word),
  .cpu_granted  (cpu_granted)
);

// File: tb/tb_prgram_ctrl.sv
`timescale 1ns/1ps
module tb_prgram_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_word = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        prot_wr = 1'b0;
  logic [7:0]  prot_wdata = '0;
  logic        dst_wr = 1'b0, src_wr = 1'b0;
  logic [15:0] dst_wdata = '0, src_wdata = '0;
  logic        dma_start = 1'b0;
  logic [15:0] dma_words = '0;
  logic [12:0] buf_addr;
  logic [15:0] buf_rdata;
  logic        ram_we;
  logic [17:0] ram_addr;
  logic [1:0]  ram_be;
  logic [15:0] ram_wdata;
  logic        dma_busy;
  logic [7:0]  prot_q;
  logic [15:0] dst_q, src_q;

  always #2 clk = ~clk;

  // staging buffer: content is a fixed function of the word address
  assign buf_rdata = {3'b101, buf_addr} ^ 16'h3C96;

  prgram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_word(cpu_word),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .prot_wr(prot_wr),
    .prot_wdata(prot_wdata), .dst_wr(dst_wr), .dst_wdata(dst_wdata),
    .src_wr(src_wr), .src_wdata(src_wdata), .dma_start(dma_start),
    .dma_words(dma_words), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
    .ram_wdata(ram_wdata), .dma_busy(dma_busy), .prot_q(prot_q),
    .dst_q(dst_q), .src_q(src_q)
  );

  int checks = 0;
  int errors = 0;
  int dma_writes = 0;
  int busy_cycles = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int unsigned m_prot = 0, m_dst = 0, m_src = 0, m_rem = 0, m_dcur = 0, m_scur = 0;
  bit          m_busy = 1'b0;
  bit          mt_taken, mt_step;
  int unsigned mt_org;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] buf_word(input int unsigned byte_a);
    return {3'b101, 13'(byte_a >> 1)} ^ 16'h3C96;
  endfunction

  // expected port activity, compared away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int unsigned cb;
      bit ok;
      cb = cpu_addr & 32'h7FFFF;
      if (cpu_word) cb = cb & 32'h7FFFE;
      ok = cb >= m_prot * 512;
      if (cpu_wr) begin
        check(ram_we === ok, "R4", ram_we, ok);
        if (ok) begin
          check(ram_addr == 18'(cb >> 1), "R2", ram_addr, cb >> 1);
          check(ram_be == (cpu_word ? 2'b11 : ((cb & 1) != 0 ? 2'b01 : 2'b10)), "R3",
                ram_be, cpu_word ? 2'b11 : ((cb & 1) != 0 ? 2'b01 : 2'b10));
          check(ram_wdata == (cpu_word ? cpu_wdata : {2{cpu_wdata[7:0]}}), "R3",
                ram_wdata, cpu_word ? cpu_wdata : {2{cpu_wdata[7:0]}});
        end
      end else if (m_busy) begin
        check(ram_we === 1'b1, "R8", ram_we, 1);
        check(ram_addr == 18'(m_dcur >> 1), "R5", ram_addr, m_dcur >> 1);
        check(buf_addr == 13'(m_scur >> 1), "R5", buf_addr, m_scur >> 1);
        check(ram_be == 2'b11, "R12", ram_be, 2'b11);
        check(ram_wdata == buf_word(m_scur), "R12", ram_wdata, buf_word(m_scur));
      end else begin
        check(ram_we === 1'b0, "R8", ram_we, 0);
      end
      check(dma_busy === m_busy, "R8", dma_busy, m_busy);
      check(dst_q == 16'(m_dst), "R6", dst_q, m_dst);
      check(src_q == 16'(m_src), "R6", src_q, m_src);
      check(prot_q == 8'(m_prot), "R4", prot_q, m_prot);
      if (ram_we && !cpu_wr) dma_writes++;
      if (dma_busy) busy_cycles++;
    end
  end

  // reference model update
  always @(posedge clk) begin
    if (!rst_n) begin
      m_prot = 0; m_dst = 0; m_src = 0; m_rem = 0; m_dcur = 0; m_scur = 0; m_busy = 1'b0;
    end else begin
      mt_taken = dma_start && !m_busy;
      mt_step  = m_busy && !cpu_wr;
      if (mt_step) begin
        m_rem  = m_rem - 1;
        m_dcur = (m_dcur + 2) & 32'h7FFFF;
        m_scur = (m_scur + 2) & 32'h3FFF;
        if (m_rem == 0) m_busy = 1'b0;
      end
      if (mt_taken) begin
        mt_org = (m_dst << 3) & 32'h7FFFE;
        if (mt_org >= m_prot * 512 && dma_words != 0) begin
          m_busy = 1'b1;
          m_rem  = dma_words;
          m_dcur = mt_org;
          m_scur = m_src & 32'h3FFE;
        end
        m_dst = (m_dst + dma_words / 4) & 32'hFFFF;
        m_src = (m_src + 2 * dma_words) & 32'hFFFF;
      end else begin
        if (dst_wr) m_dst = dst_wdata;
        if (src_wr) m_src = src_wdata;
      end
      if (prot_wr) m_prot = prot_wdata;
    end
  end

  task automatic op_cpu(input bit w, input logic [23:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cpu_wr = 1'b1; cpu_word = w; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic op_prot(input logic [7:0] v);
    @(posedge clk); #1; prot_wr = 1'b1; prot_wdata = v;
    @(posedge clk); #1; prot_wr = 1'b0;
  endtask

  task automatic op_dst(input logic [15:0] v);
    @(posedge clk); #1; dst_wr = 1'b1; dst_wdata = v;
    @(posedge clk); #1; dst_wr = 1'b0;
  endtask

  task automatic op_src(input logic [15:0] v);
    @(posedge clk); #1; src_wr = 1'b1; src_wdata = v;
    @(posedge clk); #1; src_wr = 1'b0;
  endtask

  task automatic op_start(input logic [15:0] n);
    @(posedge clk); #1; dma_start = 1'b1; dma_words = n;
    @(posedge clk); #1; dma_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int w0, b0;
    logic [15:0] d0, s0;
    repeat (3) @(posedge clk);
    #1;
    // R1: state right after reset
    check(dma_busy === 1'b0, "R1", dma_busy, 0);
    check(ram_we === 1'b0, "R1", ram_we, 0);
    check(prot_q == 8'h00 && dst_q == 16'h0 && src_q == 16'h0, "R1", {prot_q, dst_q}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3: lane selection and address masking, no guard
    op_cpu(1'b0, 24'h000011, 16'h00AB);
    op_cpu(1'b0, 24'h000010, 16'h00CD);
    op_cpu(1'b1, 24'h000013, 16'h1234);
    op_cpu(1'b1, 24'hF80020, 16'h5678);
    op_cpu(1'b0, 24'hABCDEF, 16'hFF3C);

    // R4: floor at 1024 bytes
    op_prot(8'd2);
    op_cpu(1'b0, 24'h0003FF, 16'h0011);
    op_cpu(1'b1, 24'h0003FE, 16'h2222);
    op_cpu(1'b1, 24'h000400, 16'h3333);
    op_cpu(1'b0, 24'h080401, 16'h0044);

    // R5 R8 R12: copy starting exactly at the floor, source bits masked
    op_dst(16'h0080);
    op_src(16'h4003);
    w0 = dma_writes;
    op_start(16'd5);
    idle(8);
    check(dma_writes - w0 == 5, "R8", dma_writes - w0, 5);
    check(dst_q == 16'h0081, "R6", dst_q, 16'h0081);

    // R7: one destination unit below the floor, pointers still move
    op_dst(16'h007F);
    w0 = dma_writes; b0 = busy_cycles; s0 = src_q;
    op_start(16'd6);
    idle(8);
    check(dma_writes - w0 == 0, "R7", dma_writes - w0, 0);
    check(busy_cycles - b0 == 0, "R7", busy_cycles - b0, 0);
    check(dst_q == 16'h0080, "R6", dst_q, 16'h0080);
    check(src_q == 16'(s0 + 16'd12), "R6", src_q, 16'(s0 + 16'd12));

    // R8: wrap of destination (19 bits) and source (14 bits)
    op_prot(8'd0);
    op_dst(16'hFFFF);
    op_src(16'h3FFC);
    w0 = dma_writes;
    op_start(16'd9);
    idle(12);
    check(dma_writes - w0 == 9, "R8", dma_writes - w0, 9);

    // R9: second start during a burst is dropped
    op_dst(16'h0200);
    w0 = dma_writes; s0 = src_q;
    op_start(16'd7);
    op_start(16'd4);
    idle(10);
    check(dma_writes - w0 == 7, "R9", dma_writes - w0, 7);
    check(dst_q == 16'h0201, "R9", dst_q, 16'h0201);
    check(src_q == 16'(s0 + 16'd14), "R9", src_q, 16'(s0 + 16'd14));

    // R10: processor store steals one cycle of a burst
    op_dst(16'h0300);
    w0 = dma_writes; b0 = busy_cycles;
    op_start(16'd6);
    op_cpu(1'b1, 24'h000010, 16'hBEEF);
    idle(10);
    check(dma_writes - w0 == 6, "R10", dma_writes - w0, 6);
    check(busy_cycles - b0 == 7, "R10", busy_cycles - b0, 7);

    // R10: guarded store during a burst writes nothing and still holds the copy
    op_prot(8'd255);
    op_dst(16'hFF00);
    b0 = busy_cycles;
    op_start(16'd4);
    op_cpu(1'b1, 24'h000000, 16'h0BAD);
    idle(8);
    check(busy_cycles - b0 == 5, "R10", busy_cycles - b0, 5);
    op_prot(8'd0);

    // R11: zero-length start
    d0 = dst_q; s0 = src_q;
    w0 = dma_writes; b0 = busy_cycles;
    op_start(16'd0);
    idle(4);
    check(dma_writes - w0 == 0, "R11", dma_writes - w0, 0);
    check(busy_cycles - b0 == 0, "R11", busy_cycles - b0, 0);
    check(dst_q == d0 && src_q == s0, "R11", {dst_q, src_q}, {d0, s0});

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule